// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master with Single Data Strobe

This block lets a core reach external devices over a shared address/data bus. The bus has an active-low address strobe and one active-low data strobe that serves both transfer directions. A level signal, `rnw`, tells the addressed device whether the current cycle reads or writes. The core side is a simple request/ready port. A request is accepted in any cycle where `req_ready` is high. Completion is reported by a one-cycle `rsp_done` pulse, and for reads the captured data comes with it.

Each bus cycle runs through fixed phases. First the address phase: `as_n` is low and the address is driven. Then a turnaround phase with both strobes high: the address is released, and for a write the write data is already on the bus. Then the data phase: `ds_n` is low. A write ends with one extra clock that holds the write data after `ds_n` rises. Three parameters set the lengths of the address, turnaround and data phases in clocks. The shared lines go through `bus_out`/`bus_oe`/`bus_in` to an external tristate pad.

Top module: `mxds_bus_master`

## Requirements
- R1: After reset and while idle: `as_n`=1, `ds_n`=1, `rnw`=1, `bus_oe`=0, `req_ready`=1 and `rsp_done`=0.
- R2: A clock edge with `req_valid`=1 and `req_ready`=1 accepts a request. For the next AS_CYC cycles `as_n`=0, `bus_oe`=1 and `bus_out` equals the accepted `req_addr`. `req_ready` stays 0 until the done cycle, and requests presented while it is 0 have no effect.
- R3: After the address phase, `as_n` and `ds_n` are both 1 for GAP_CYC cycles. The address is no longer driven: `bus_oe`=0 for a read, and `bus_out` carries the write data for a write.
- R4: `rnw` is 1 for a read (`req_write`=0) and 0 for a write (`req_write`=1). It takes that value in the first address cycle and stays constant until `ds_n` has risen.
- R5: In a read, `ds_n` is 0 for DS_CYC cycles with `bus_oe`=0. `rsp_rdata` is the value of `bus_in` during the last of those cycles. Values of `bus_in` in other cycles do not affect it.
- R6: In a write, `bus_oe`=1 and `bus_out` equals the accepted `req_wdata` through the turnaround phase, the DS_CYC cycles with `ds_n`=0, and one more cycle after `ds_n` rises. In that extra cycle both strobes are 1 and `rnw` is 0.
- R7: `rsp_done` is a one-cycle pulse. For a read it comes in the cycle after the last `ds_n`=0 cycle; for a write it comes one cycle later, after the hold cycle. In the done cycle the block is idle again (R1 values, except `rsp_done`=1).
- R8: `bus_out` is all zeros whenever `bus_oe` is 0.
- R9: `as_n` and `ds_n` are never 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core requests a bus cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | BUS_W | Address for the cycle |
| req_wdata | input | BUS_W | Write data |
| req_ready | output | 1 | Block is idle and accepts a request |
| rsp_done | output | 1 | One-cycle pulse at the end of a cycle |
| rsp_rdata | output | BUS_W | Data captured by the last read |
| bus_out | output | BUS_W | Value driven onto the shared lines |
| bus_oe | output | 1 | Output enable for the shared lines |
| bus_in | input | BUS_W | Value seen on the shared lines |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rnw | output | 1 | Direction level, 1 = read |

## Verification
A wrong phase or count state shows at the strobes in the same cycle. A strobe opens early or stays open too long, and `rsp_done` lands one or more cycles off its expected position. A wrongly latched direction flag shows at once as a wrong `rnw` level or a wrong `bus_oe` in the turnaround. A capture taken at the wrong moment shows in `rsp_rdata` at the done pulse, because the bench places the expected read value on `bus_in` only in the last data-strobe cycle.

// File: rtl/mxds_pkg.sv
package mxds_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_TURN = 3'd2,
        PH_DATA = 3'd3,
        PH_HOLD = 3'd4
    } phase_e;
endpackage

// File: rtl/mxds_seq.sv
module mxds_seq
    import mxds_pkg::*;
#(
    parameter int AS_CYC  = 2,
    parameter int GAP_CYC = 1,
    parameter int DS_CYC  = 3
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  logic   req_write,
    output logic   req_ready,
    output phase_e phase,
    output logic   is_write,
    output logic   cap_en,
    output logic   done
);
    localparam int LEN_MAX = (AS_CYC > GAP_CYC) ?
                             ((AS_CYC > DS_CYC) ? AS_CYC : DS_CYC) :
                             ((GAP_CYC > DS_CYC) ? GAP_CYC : DS_CYC);
    localparam int CNT_W   = (LEN_MAX > 1) ? $clog2(LEN_MAX) : 1;

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             wr;
        logic             done;
    } seq_t;

    seq_t q, d;
    logic last;

    assign last = (q.cnt == '0);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        cap_en = 1'b0;
        case (q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    d.phase = PH_ADDR;
                    d.cnt   = CNT_W'(AS_CYC - 1);
                    d.wr    = req_write;
                end
            end
            PH_ADDR: begin
                if (last) begin
                    d.phase = PH_TURN;
                    d.cnt   = CNT_W'(GAP_CYC - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_TURN: begin
                if (last) begin
                    d.phase = PH_DATA;
                    d.cnt   = CNT_W'(DS_CYC - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_DATA: begin
                if (last) begin
                    if (q.wr) begin
                        d.phase = PH_HOLD;
                    end else begin
                        d.phase = PH_IDLE;
                        d.done  = 1'b1;
                        cap_en  = 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                d.phase = PH_IDLE;
                d.done  = 1'b1;
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, cnt: '0, wr: 1'b0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.phase == PH_IDLE);
    assign phase     = q.phase;
    assign is_write  = q.wr;
    assign done      = q.done;
endmodule

// File: rtl/mxds_pad.sv
module mxds_pad
    import mxds_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [BUS_W-1:0] req_addr,
    input  logic [BUS_W-1:0] req_wdata,
    input  phase_e           phase,
    input  logic             is_write,
    input  logic             cap_en,
    input  logic [BUS_W-1:0] bus_in,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe,
    output logic             as_n,
    output logic             ds_n,
    output logic             rnw,
    output logic [BUS_W-1:0] rdata
);
    typedef struct packed {
        logic [BUS_W-1:0] addr;
        logic [BUS_W-1:0] wdat;
        logic [BUS_W-1:0] rdat;
    } pad_t;

    pad_t q, d;
    logic in_addr, wr_drive;

    always_comb begin
        d = q;
        if (accept) begin
            d.addr = req_addr;
            d.wdat = req_wdata;
        end
        if (cap_en) begin
            d.rdat = bus_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign in_addr  = (phase == PH_ADDR);
    assign wr_drive = is_write && ((phase == PH_TURN) || (phase == PH_DATA) ||
                                   (phase == PH_HOLD));

    always_comb begin
        as_n    = !in_addr;
        ds_n    = (phase != PH_DATA);
        rnw     = (phase == PH_IDLE) ? 1'b1 : !is_write;
        bus_oe  = in_addr || wr_drive;
        bus_out = in_addr ? q.addr : (wr_drive ? q.wdat : '0);
    end

    assign rdata = q.rdat;
endmodule

// File: rtl/mxds_bus_master.sv
module mxds_bus_master
    import mxds_pkg::*;
#(
    parameter int BUS_W   = 16,
    parameter int AS_CYC  = 2,
    parameter int GAP_CYC = 1,
    parameter int DS_CYC  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [BUS_W-1:0] req_addr,
    input  logic [BUS_W-1:0] req_wdata,
    output logic             req_ready,
    output logic             rsp_done,
    output logic [BUS_W-1:0] rsp_rdata,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe,
    input  logic [BUS_W-1:0] bus_in,
    output logic             as_n,
    output logic             ds_n,
    output logic             rnw
);
    phase_e phase;
    logic   is_write, cap_en, ready_w;

    mxds_seq #(
        .AS_CYC (AS_CYC),
        .GAP_CYC(GAP_CYC),
        .DS_CYC (DS_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_ready(ready_w),
        .phase    (phase),
        .is_write (is_write),
        .cap_en   (cap_en),
        .done     (rsp_done)
    );

    mxds_pad #(
        .BUS_W(BUS_W)
    ) u_pad (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (req_valid && ready_w),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .phase    (phase),
        .is_write (is_write),
        .cap_en   (cap_en),
        .bus_in   (bus_in),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe),
        .as_n     (as_n),
        .ds_n     (ds_n),
        .rnw      (rnw),
        .rdata    (rsp_rdata)
    );

    assign req_ready = ready_w;
endmodule

// File: rtl/mxds_bus_master_chk.sv
module mxds_bus_master_chk #(
    parameter int BUS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rsp_done,
    input logic [BUS_W-1:0] bus_out,
    input logic             bus_oe,
    input logic             as_n,
    input logic             ds_n,
    input logic             rnw
);
    a_r1_ready_means_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (as_n && ds_n && rnw && !bus_oe));

    a_r3_read_turn_released: assert property (@(posedge clk) disable iff (!rst_n)
        (as_n && $past(!as_n) && rnw) |-> !bus_oe);

    a_r3_addr_before_data: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ds_n) |-> $past(as_n));

    a_r4_rnw_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ds_n) |-> $stable(rnw));

    a_r4_rnw_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n && $past(!ds_n)) |-> $stable(rnw));

    a_r5_read_tristate: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n && rnw) |-> !bus_oe);

    a_r6_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ds_n) && !rnw) |-> (bus_oe && $stable(bus_out)));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);

    a_r8_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_out == '0));

    a_r9_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(!as_n && !ds_n));
endmodule

bind mxds_bus_master mxds_bus_master_chk #(.BUS_W(BUS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .rsp_done (rsp_done),
    .bus_out  (bus_out),
    .bus_oe   (bus_oe),
    .as_n     (as_n),
    .ds_n     (ds_n),
    .rnw      (rnw)
);

// File: tb/mxds_bus_master_bench.sv
module mxds_bus_master_bench;
    localparam int W   = 16;
    localparam int AS  = 2;
    localparam int GAP = 1;
    localparam int DS  = 3;

    typedef struct packed {
        logic         as_n;
        logic         ds_n;
        logic         rnw;
        logic         oe;
        logic [W-1:0] out;
        logic         ready;
        logic         done;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [W-1:0] req_addr = '0;
    logic [W-1:0] req_wdata = '0;
    logic         req_ready, rsp_done, bus_oe, as_n, ds_n, rnw;
    logic [W-1:0] rsp_rdata, bus_out;
    logic [W-1:0] bus_in = '0;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;

    always #10 clk = ~clk;

    mxds_bus_master #(
        .BUS_W(W), .AS_CYC(AS), .GAP_CYC(GAP), .DS_CYC(DS)
    ) u_mxds_bus_master (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
        .as_n(as_n), .ds_n(ds_n), .rnw(rnw)
    );

    function automatic exp_t idle_exp(input logic dn);
        return '{as_n: 1'b1, ds_n: 1'b1, rnw: 1'b1, oe: 1'b0, out: '0,
                 ready: 1'b1, done: dn};
    endfunction

    // Expected port values k cycles after the accepting edge.
    function automatic exp_t cyc_exp(input int k, input logic wr,
                                     input logic [W-1:0] a, input logic [W-1:0] wd);
        exp_t e;
        e = '{as_n: 1'b1, ds_n: 1'b1, rnw: !wr, oe: wr, out: wr ? wd : '0,
              ready: 1'b0, done: 1'b0};
        if (k <= AS) begin
            e.as_n = 1'b0; e.oe = 1'b1; e.out = a;
        end else if (k <= AS + GAP) begin
            // turnaround: defaults hold
        end else if (k <= AS + GAP + DS) begin
            e.ds_n = 1'b0;
        end else if (wr && k == AS + GAP + DS + 1) begin
            // write hold cycle: defaults hold
        end else begin
            e = idle_exp(1'b1);
        end
        return e;
    endfunction

    function automatic string tag_of(input int k, input logic wr);
        if (k <= AS) return "R2";
        if (k <= AS + GAP) return "R3";
        if (k <= AS + GAP + DS) return wr ? "R6" : "R5";
        if (wr && k == AS + GAP + DS + 1) return "R6";
        return "R7";
    endfunction

    task automatic cmp(input string tag, input exp_t e);
        exp_t act;
        act = '{as_n: as_n, ds_n: ds_n, rnw: rnw, oe: bus_oe, out: bus_out,
                ready: req_ready, done: rsp_done};
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: as_n/ds_n/rnw/oe/out/ready/done actual %b/%b/%b/%b/%h/%b/%b expected %b/%b/%b/%b/%h/%b/%b",
                     tag, act.as_n, act.ds_n, act.rnw, act.oe, act.out, act.ready, act.done,
                     e.as_n, e.ds_n, e.rnw, e.oe, e.out, e.ready, e.done);
        end
        checks++;
        if (!as_n && !ds_n) begin
            errors++;
            $display("FAIL R9: both strobes low actual as_n=%b ds_n=%b expected not both 0",
                     as_n, ds_n);
        end
        checks++;
        if (!bus_oe && bus_out !== '0) begin
            errors++;
            $display("FAIL R8: bus_out actual %h expected 0 with bus_oe low", bus_out);
        end
    endtask

    task automatic run_txn(input logic wr, input logic [W-1:0] a,
                           input logic [W-1:0] wd, input logic [W-1:0] rd,
                           input bit poke);
        int total;
        total = AS + GAP + DS + 1 + (wr ? 1 : 0);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        bus_in = W'($urandom);
        cmp("R1", idle_exp(1'b0));
        for (int k = 1; k <= total; k++) begin
            @(negedge clk);
            // busy-time requests must be ignored (R2); none in the done cycle
            req_valid = poke && (k < total) ? 1'b1 : 1'b0;
            req_write = 1'($urandom);
            req_addr  = W'($urandom);
            req_wdata = W'($urandom);
            bus_in    = (k == AS + GAP + DS) ? rd : W'($urandom);
            cmp(tag_of(k, wr), cyc_exp(k, wr, a, wd));
            // R4: direction level during the strobe
            if (k > AS && k <= AS + GAP + DS) begin
                checks++;
                if (rnw !== !wr) begin
                    errors++;
                    $display("FAIL R4: rnw actual %b expected %b", rnw, !wr);
                end
            end
        end
        if (!wr) begin
            checks++;
            if (rsp_rdata !== rd) begin
                errors++;
                $display("FAIL R5: rsp_rdata actual %h expected %h", rsp_rdata, rd);
            end
        end
    endtask

    initial begin
        logic [W-1:0] last_rd;
        void'($urandom(32'h5EED_0042));
        #5;
        @(negedge clk);
        cmp("R1", idle_exp(1'b0));
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R1", idle_exp(1'b0));

        // directed corners
        run_txn(1'b0, 16'hFFFF, 16'h0000, 16'hFFFF, 1'b0);
        last_rd = 16'hFFFF;
        run_txn(1'b1, 16'h0000, 16'h0000, 16'h1234, 1'b1);
        // a write leaves the last read value untouched (R5)
        checks++;
        if (rsp_rdata !== last_rd) begin
            errors++;
            $display("FAIL R5: rsp_rdata after write actual %h expected %h", rsp_rdata, last_rd);
        end
        run_txn(1'b1, 16'hA5A5, 16'hFFFF, 16'h0000, 1'b0);
        run_txn(1'b0, 16'h8001, 16'h7FFE, 16'h0000, 1'b1);

        // random mix
        for (int n = 0; n < 60; n++) begin
            run_txn(1'($urandom), W'($urandom), W'($urandom), W'($urandom),
                    1'($urandom));
            if ($urandom_range(0, 3) == 0) begin
                @(negedge clk);
                cmp("R1", idle_exp(1'b0));
            end
        end

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R7: watchdog expired, actual no completion expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule